// File: doc/BRIEF.md
# Conversion Completion Flag Controller

This block keeps one completion flag for each of ten positions in a conversion sequence. The flags follow the slot position in the sequence, not the input channel, and flag n always pairs with result register n. When the converter reports that slot n has finished, the block does one of two things. It can store the result in register n and raise flag n. Or, if compare is enabled for that slot, it treats register n as a compare value, tests the new result against it, throws the result away and raises the flag only when the test is true.

Software reaches the block through a simple register bus. Writes take effect on the clock edge. Read data is combinational from the address. There are four ways to clear flags: a write to the sequence-start address; writing ones to the flag register; reading a result register when fast-clear mode is on; and writing a compare value when fast-clear mode is on. A compare interrupt is raised while a flag set by a successful compare is pending and the interrupt enable is on.

Top module: `seq_flag_ctrl`

## Requirements
- R1: After reset all flags, result registers, compare enables, operator bits, the fast-clear bit and the interrupt enable are zero, and `cmpIrq` is low.
- R2: When `doneValid` is high with `doneSlot` = n (n from 0 to 9) and compare is off for slot n, flag n is set and `doneResult` is stored in result register n at that clock edge. A `doneSlot` of 10 or more is ignored.
- R3: When compare is on for slot n, result register n keeps its value. Flag n is set only if the unsigned 12-bit test is true. With operator bit 1 the test is result > compare value. With operator bit 0 the test is result <= compare value.
- R4: `cmpIrq` is high exactly when the interrupt enable (control bit 1) is set and at least one set flag was raised by a successful compare. It drops once those flags are cleared or the enable is cleared.
- R5: Any write to address 14 (sequence start) clears every flag at that edge. This clear beats a completion arriving in the same cycle.
- R6: With fast-clear mode off (control bit 0 = 0), a write to address 10 clears each flag whose data bit is 1 and leaves the other flags alone. With fast-clear mode on, a write to address 10 has no effect on the flags.
- R7: With fast-clear mode on, a read of result address n clears flag n if compare is off for slot n. A write to result address n clears flag n if compare is on for slot n. A read with compare on, a write with compare off, and any result access with fast-clear mode off all leave the flag as it is.
- R8: A completion that sets flag n beats a same-cycle clear of flag n by a write of ones, a fast-clear read or a fast-clear write.
- R9: Address map: result register n is at address n (0 to 9). Flags are at 10, compare enables at 11 (bit n = slot n), operator bits at 12 (bit n = slot n), control at 13 (bit 0 fast-clear, bit 1 interrupt enable) and sequence start at 14. Unused bits and addresses read as zero. A result stored by a completion beats a bus write to the same result register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe (needed for clear-on-read) |
| addr | input | 5 | Register address |
| wrData | input | 12 | Write data |
| rdData | output | 12 | Read data for `addr`, combinational |
| doneValid | input | 1 | Conversion finished strobe |
| doneSlot | input | 4 | Sequence position of the finished conversion |
| doneResult | input | 12 | Conversion result |
| flagVec | output | 10 | Completion flags, bit n = slot n |
| cmpIrq | output | 1 | Compare interrupt request |

## Verification
A flag in the wrong state appears on `flagVec` on the very next cycle. The cause can be a lost set, a clear that should not have happened, or the wrong side winning a set/clear collision. A wrong compare operator or a result register that should not have been overwritten does not show at once. It surfaces later: in the flag outcome of the next compare on that slot, or in the value a read of that result address returns. A stale or wrongly set compare-hit marker shows on `cmpIrq` in the cycle after the flag changes, or at once when the interrupt enable is toggled.

// File: rtl/seq_flag_pkg.sv
package seq_flag_pkg;
  localparam int SEQ_SLOTS  = 10;
  localparam int SLOT_IDX_W = $clog2(SEQ_SLOTS);

  typedef enum logic [2:0] {
    RD_NONE, RD_RES, RD_FLAG, RD_CMPEN, RD_CMPOP, RD_CTRL
  } rdSel_e;

  typedef struct packed {
    logic                  resWr;
    logic                  resRd;
    logic                  flagWr;
    logic                  cmpEnWr;
    logic                  cmpOpWr;
    logic                  ctrlWr;
    logic                  seqStart;
    rdSel_e                rdSel;
    logic [SLOT_IDX_W-1:0] slot;
  } busStrobe_t;
endpackage

// File: rtl/seq_flag_ctl.sv
module seq_flag_ctl
  import seq_flag_pkg::*;
#(
  parameter int NUM_SLOTS = SEQ_SLOTS,
  parameter int ADDR_W    = 5
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output busStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_CMPEN = ADDR_W'(NUM_SLOTS + 1);
  localparam logic [ADDR_W-1:0] A_CMPOP = ADDR_W'(NUM_SLOTS + 2);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(NUM_SLOTS + 3);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(NUM_SLOTS + 4);

  logic isRes;
  assign isRes = addr < A_FLAG;

  always_comb begin
    strb          = '0;
    strb.slot     = SLOT_IDX_W'(addr);
    strb.resWr    = wrEn && isRes;
    strb.resRd    = rdEn && isRes;
    strb.flagWr   = wrEn && (addr == A_FLAG);
    strb.cmpEnWr  = wrEn && (addr == A_CMPEN);
    strb.cmpOpWr  = wrEn && (addr == A_CMPOP);
    strb.ctrlWr   = wrEn && (addr == A_CTRL);
    strb.seqStart = wrEn && (addr == A_START);
    if (isRes)                strb.rdSel = RD_RES;
    else if (addr == A_FLAG)  strb.rdSel = RD_FLAG;
    else if (addr == A_CMPEN) strb.rdSel = RD_CMPEN;
    else if (addr == A_CMPOP) strb.rdSel = RD_CMPOP;
    else if (addr == A_CTRL)  strb.rdSel = RD_CTRL;
    else                      strb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/seq_flag_dp.sv
module seq_flag_dp
  import seq_flag_pkg::*;
#(
  parameter int NUM_SLOTS = SEQ_SLOTS,
  parameter int DATA_W    = 12,
  parameter int BUS_W     = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobe_t            strb,
  input  logic [BUS_W-1:0]      wrData,
  output logic [BUS_W-1:0]      rdData,
  input  logic                  doneValid,
  input  logic [SLOT_IDX_W-1:0] doneSlot,
  input  logic [DATA_W-1:0]     doneResult,
  output logic [NUM_SLOTS-1:0]  flagVec,
  output logic                  cmpIrq,
  output logic                  fastClear,
  output logic                  irqEn
);
  logic [DATA_W-1:0]    resReg [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] cmpEn, cmpOp, cmpHit, flags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpEn     <= '0;
      cmpOp     <= '0;
      fastClear <= 1'b0;
      irqEn     <= 1'b0;
    end else begin
      if (strb.cmpEnWr) cmpEn <= wrData[NUM_SLOTS-1:0];
      if (strb.cmpOpWr) cmpOp <= wrData[NUM_SLOTS-1:0];
      if (strb.ctrlWr) begin
        fastClear <= wrData[0];
        irqEn     <= wrData[1];
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic slotDone, cmpTrue, setFlag, busSel, clrFlag;
    assign slotDone = doneValid && (doneSlot == SLOT_IDX_W'(g));
    assign cmpTrue  = cmpOp[g] ? (doneResult >  resReg[g])
                               : (doneResult <= resReg[g]);
    assign setFlag  = slotDone && (!cmpEn[g] || cmpTrue);
    assign busSel   = strb.slot == SLOT_IDX_W'(g);
    assign clrFlag  = (strb.flagWr && !fastClear && wrData[g]) ||
                      (fastClear && busSel &&
                       ((strb.resRd && !cmpEn[g]) || (strb.resWr && cmpEn[g])));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flags[g]  <= 1'b0;
        cmpHit[g] <= 1'b0;
      end else if (strb.seqStart) begin
        flags[g]  <= 1'b0;
        cmpHit[g] <= 1'b0;
      end else if (setFlag) begin
        flags[g]  <= 1'b1;
        cmpHit[g] <= cmpEn[g];
      end else if (clrFlag) begin
        flags[g]  <= 1'b0;
        cmpHit[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      resReg[g] <= '0;
      else if (slotDone && !cmpEn[g]) resReg[g] <= doneResult;
      else if (strb.resWr && busSel)  resReg[g] <= wrData[DATA_W-1:0];
    end
  end

  assign flagVec = flags;
  assign cmpIrq  = irqEn && |(flags & cmpHit);

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_RES:   rdData[DATA_W-1:0]    = resReg[strb.slot];
      RD_FLAG:  rdData[NUM_SLOTS-1:0] = flags;
      RD_CMPEN: rdData[NUM_SLOTS-1:0] = cmpEn;
      RD_CMPOP: rdData[NUM_SLOTS-1:0] = cmpOp;
      RD_CTRL:  rdData[1:0]           = {irqEn, fastClear};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/seq_flag_ctrl.sv
module seq_flag_ctrl
  import seq_flag_pkg::*;
#(
  parameter int NUM_SLOTS = SEQ_SLOTS,
  parameter int DATA_W    = 12,
  parameter int ADDR_W    = 5,
  parameter int BUS_W     = (NUM_SLOTS > DATA_W) ? NUM_SLOTS : DATA_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BUS_W-1:0]      wrData,
  output logic [BUS_W-1:0]      rdData,
  input  logic                  doneValid,
  input  logic [SLOT_IDX_W-1:0] doneSlot,
  input  logic [DATA_W-1:0]     doneResult,
  output logic [NUM_SLOTS-1:0]  flagVec,
  output logic                  cmpIrq
);
  busStrobe_t strb;
  logic       fastClear, irqEn;

  seq_flag_ctl #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) ctl_i (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strb(strb)
  );

  seq_flag_dp #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .BUS_W(BUS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .doneValid(doneValid), .doneSlot(doneSlot), .doneResult(doneResult),
    .flagVec(flagVec), .cmpIrq(cmpIrq), .fastClear(fastClear), .irqEn(irqEn)
  );
endmodule

// File: rtl/seq_flag_chk.sv
module seq_flag_chk #(
  parameter int NUM_SLOTS = 10,
  parameter int ADDR_W    = 5,
  parameter int BUS_W     = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [BUS_W-1:0]     wrData,
  input logic                 doneValid,
  input logic [NUM_SLOTS-1:0] flagVec,
  input logic                 cmpIrq,
  input logic                 fastClear,
  input logic                 irqEn
);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(NUM_SLOTS + 4);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (flagVec == '0 && !cmpIrq));

  // R2
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec & ~$past(flagVec)) != '0) |-> $past(doneValid));

  // R4
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpIrq |-> (irqEn && flagVec != '0));

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_START) |=> (flagVec == '0));

  // R6
  write_one_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_FLAG && !fastClear && !doneValid)
      |=> ((flagVec & $past(wrData[NUM_SLOTS-1:0])) == '0));

  // R6
  fast_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_FLAG && fastClear && !doneValid) |=> $stable(flagVec));
endmodule

bind seq_flag_ctrl seq_flag_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .doneValid(doneValid), .flagVec(flagVec), .cmpIrq(cmpIrq),
  .fastClear(fastClear), .irqEn(irqEn)
);

// File: tb/seq_flag_ctrl_tb_top.sv
module seq_flag_ctrl_tb_top;
  localparam int N = 10;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, doneValid = 1'b0;
  logic [4:0]  addr = '0;
  logic [11:0] wrData = '0, doneResult = '0, rdData;
  logic [3:0]  doneSlot = '0;
  logic [9:0]  flagVec;
  logic        cmpIrq;

  int nChecks = 0, nFails = 0;

  logic [11:0] mRes [N];
  logic [9:0]  mFlag, mHit, mEn, mOp;
  logic        mFast, mIrqEn;

  always #(CLK_NS/2) clk = ~clk;

  seq_flag_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .doneValid(doneValid),
    .doneSlot(doneSlot), .doneResult(doneResult), .flagVec(flagVec),
    .cmpIrq(cmpIrq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] modelRead(logic [4:0] a);
    if (a < 5'(N)) return mRes[a];
    case (a)
      5'd10: return {2'b0, mFlag};
      5'd11: return {2'b0, mEn};
      5'd12: return {2'b0, mOp};
      5'd13: return {10'b0, mIrqEn, mFast};
      default: return 12'h0;
    endcase
  endfunction

  function automatic logic modelIrq();
    return mIrqEn && |(mFlag & mHit);
  endfunction

  task automatic modelStep();
    logic [9:0] nf = mFlag, nh = mHit;
    for (int n = 0; n < N; n++) begin
      logic hitSlot, cmp, setF, clrF;
      hitSlot = doneValid && (doneSlot == 4'(n));
      cmp  = mOp[n] ? (doneResult > mRes[n]) : (doneResult <= mRes[n]);
      setF = hitSlot && (!mEn[n] || cmp);
      clrF = (wrEn && addr == 5'd10 && !mFast && wrData[n]) ||
             (mFast && addr == 5'(n) && ((rdEn && !mEn[n]) || (wrEn && mEn[n])));
      if (wrEn && addr == 5'd14) begin nf[n] = 1'b0; nh[n] = 1'b0; end
      else if (setF) begin nf[n] = 1'b1; nh[n] = mEn[n]; end
      else if (clrF) begin nf[n] = 1'b0; nh[n] = 1'b0; end
      if (hitSlot && !mEn[n]) mRes[n] = doneResult;
      else if (wrEn && addr == 5'(n)) mRes[n] = wrData;
    end
    mFlag = nf;
    mHit  = nh;
    if (wrEn && addr == 5'd11) mEn = wrData[9:0];
    if (wrEn && addr == 5'd12) mOp = wrData[9:0];
    if (wrEn && addr == 5'd13) begin mFast = wrData[0]; mIrqEn = wrData[1]; end
  endtask

  // Drive one cycle, check read data before the edge, flags and irq after it.
  task automatic cyc(string tag, logic w, logic r, logic [4:0] a, logic [11:0] d,
                     logic dv, logic [3:0] ds, logic [11:0] dr);
    @(negedge clk);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    doneValid = dv; doneSlot = ds; doneResult = dr;
    #1;
    if (r) check({tag, " read"}, 32'(rdData), 32'(modelRead(a)));
    modelStep();
    @(posedge clk);
    #1;
    check({tag, " flags"}, 32'(flagVec), 32'(mFlag));
    check({tag, " irq"}, 32'(cmpIrq), 32'(modelIrq()));
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 5'd31, 12'h0, 0, 4'd0, 12'h0);
  endtask

  task automatic rd(string tag, logic [4:0] a);
    cyc(tag, 0, 1, a, 12'h0, 0, 4'd0, 12'h0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < N; n++) mRes[n] = '0;
    mFlag = '0; mHit = '0; mEn = '0; mOp = '0; mFast = 1'b0; mIrqEn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flags", 32'(flagVec), 0);
    check("R1 reset irq", 32'(cmpIrq), 0);
    @(negedge clk) rstN = 1'b1;
    rd("R1 result zero", 5'd3);
    rd("R1 ctrl zero", 5'd13);

    // R2 store and flag
    cyc("R2 done slot2", 0, 0, 5'd31, 0, 1, 4'd2, 12'h5A5);
    check("R2 flag2 set", 32'(flagVec), 32'h004);
    rd("R2 result2", 5'd2);
    check("R2 result2 value", 32'(rdData), 32'h5A5);
    cyc("R2 out of range slot", 0, 0, 5'd31, 0, 1, 4'd12, 12'h111);
    check("R2 slot12 ignored", 32'(flagVec), 32'h004);

    // R6 write-one clear
    cyc("R6 write zero", 1, 0, 5'd10, 12'h000, 0, 0, 0);
    check("R6 zero keeps", 32'(flagVec), 32'h004);
    cyc("R6 write one", 1, 0, 5'd10, 12'h004, 0, 0, 0);
    check("R6 one clears", 32'(flagVec), 32'h000);

    // R3 compare mode
    cyc("R9 cmpen", 1, 0, 5'd11, 12'h010, 0, 0, 0);
    cyc("R9 cmpop", 1, 0, 5'd12, 12'h010, 0, 0, 0);
    cyc("R3 load cmp", 1, 0, 5'd4, 12'd100, 0, 0, 0);
    cyc("R3 gt true", 0, 0, 5'd31, 0, 1, 4'd4, 12'd150);
    check("R3 gt flag", 32'(flagVec), 32'h010);
    rd("R3 value kept", 5'd4);
    check("R3 value kept 100", 32'(rdData), 32'd100);
    cyc("R6 clr4", 1, 0, 5'd10, 12'h010, 0, 0, 0);
    cyc("R3 gt equal false", 0, 0, 5'd31, 0, 1, 4'd4, 12'd100);
    check("R3 equal not gt", 32'(flagVec), 32'h000);
    cyc("R3 op le", 1, 0, 5'd12, 12'h000, 0, 0, 0);
    cyc("R3 le equal true", 0, 0, 5'd31, 0, 1, 4'd4, 12'd100);
    check("R3 le flag", 32'(flagVec), 32'h010);

    // R4 interrupt
    check("R4 irq off", 32'(cmpIrq), 0);
    cyc("R4 enable", 1, 0, 5'd13, 12'h002, 0, 0, 0);
    check("R4 irq on", 32'(cmpIrq), 1);
    cyc("R4 plain flag", 0, 0, 5'd31, 0, 1, 4'd1, 12'h033);

    // R5 start clear beats set
    cyc("R5 start with set", 1, 0, 5'd14, 12'h0, 1, 4'd1, 12'h044);
    check("R5 all clear", 32'(flagVec), 0);
    check("R4 irq drops", 32'(cmpIrq), 0);

    // R7 fast clear
    cyc("R7 fast on", 1, 0, 5'd13, 12'h003, 0, 0, 0);
    cyc("R7 done0", 0, 0, 5'd31, 0, 1, 4'd0, 12'h077);
    rd("R7 read0 clears", 5'd0);
    check("R7 read0", 32'(flagVec), 0);
    cyc("R7 done4", 0, 0, 5'd31, 0, 1, 4'd4, 12'd50);
    rd("R7 read4 keeps", 5'd4);
    check("R7 read cmp slot", 32'(flagVec), 32'h010);
    cyc("R6 fast write ignored", 1, 0, 5'd10, 12'h3FF, 0, 0, 0);
    check("R6 ignored", 32'(flagVec), 32'h010);
    cyc("R7 write4 clears", 1, 0, 5'd4, 12'd100, 0, 0, 0);
    check("R7 write4", 32'(flagVec), 0);
    cyc("R7 done6", 0, 0, 5'd31, 0, 1, 4'd6, 12'h066);
    cyc("R7 write6 plain", 1, 0, 5'd6, 12'h001, 0, 0, 0);
    check("R7 write no-cmp keeps", 32'(flagVec), 32'h040);

    // R8 set wins
    cyc("R8 read0 and set", 0, 1, 5'd0, 0, 1, 4'd0, 12'h099);
    check("R8 set beats read", 32'(flagVec), 32'h041);
    cyc("R8 write4 and set", 1, 0, 5'd4, 12'd100, 1, 4'd4, 12'd20);
    check("R8 set beats write", 32'(flagVec), 32'h051);

    // R9 completion beats bus write
    cyc("R9 collide5", 1, 0, 5'd5, 12'hABC, 1, 4'd5, 12'h123);
    rd("R9 result5", 5'd5);
    check("R9 done wins", 32'(rdData), 32'h123);
    rd("R9 ctrl", 5'd13);
    rd("R9 empty addr", 5'd20);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic w, r, dv;
      logic [4:0] a;
      logic [11:0] d, dr;
      int sel = $urandom_range(0, 99);
      a  = 5'($urandom_range(0, 15));
      w  = ($urandom_range(0, 3) == 0);
      r  = ($urandom_range(0, 2) == 0);
      dv = ($urandom_range(0, 1) == 0);
      d  = 12'($urandom);
      dr = 12'($urandom_range(0, 15));
      if (a == 5'd14 && $urandom_range(0, 3) != 0) w = 1'b0;
      if (a < 5'd10 && w) d = 12'($urandom_range(0, 15));
      if (sel < 3) begin w = 1'b1; a = 5'($urandom_range(11, 13)); end
      cyc("R8 random", w, r, a, d, dv, 4'($urandom_range(0, 11)), dr);
    end
    idle("R1 end");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule